// File: doc/BRIEF.md
# Stack Frame Release Sequencer

This block runs the multi-cycle part of a frame release instruction. A start strobe brings in a 5-bit immediate, a 12-bit register mask, a flag that requests a jump, the jump target and the current stack pointer. The sequencer first raises the stack pointer by the immediate scaled to words. It then pops one word per set mask bit from the stack into the register file, moving the stack pointer up one word after each pop. When the jump flag is set, it writes the target to the program counter output at the end.

Memory reads use a valid/ready handshake, and the read data is taken in the cycle that ready is high. While ready stays low, the sequencer holds the request and does nothing else. Stack pointer writes and register writes leave on separate strobes. A core can therefore retire each update in order, and a bench can see the order too.

Top module: `frame_pop_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, `busy_o`, `done_o`, `rd_valid_o`, `sp_we_o`, `rf_we_o` and `pc_we_o` are all low.
- R2: Two cycles after a start is accepted in idle, `sp_we_o` pulses alone with `sp_i + 4*imm_i`, where the immediate is zero-extended. No register write happens in that cycle.
- R3: Set mask bits are popped in ascending bit order, starting at the adjusted stack pointer. Bit k writes register index 20+k through `rf_waddr_o`, so bit 0 maps to 20 and bit 11 to 31. The data written is the word returned for that address.
- R4: Every register write comes with a stack pointer write in the same cycle, with value read address + 4.
- R5: While `rd_valid_o` is high and `rd_ready_i` is low, the read address stays stable and no register write follows.
- R6: When memory is always ready, `busy_o` is high for exactly N+1 cycles for a plain release, where N is the number of set mask bits. `done_o` pulses for one cycle in the first idle cycle.
- R7: With the jump flag set, `busy_o` is high for N+3 cycles when memory is always ready. `pc_we_o` pulses with `pc_o` equal to the latched target, in the same cycle as `done_o`.
- R8: An empty mask issues no read and no register write. It does only the stack pointer adjustment, plus the jump if requested.
- R9: A start strobe while busy is ignored, and the running release finishes with the values it started with.
- R10: A plain release never pulses `pc_we_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe, accepted only when idle |
| imm_i | input | 5 | Frame size in words |
| mask_i | input | 12 | Registers to pop, bit k for register 20+k |
| jump_i | input | 1 | Jump to `jump_target_i` after the pops |
| jump_target_i | input | 32 | Jump target value |
| sp_i | input | 32 | Stack pointer at start |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rd_valid_o | output | 1 | Read request valid |
| rd_addr_o | output | 32 | Read address (current stack pointer) |
| rd_ready_i | input | 1 | Read accepted, data valid this cycle |
| rd_data_i | input | 32 | Read data |
| sp_we_o | output | 1 | Stack pointer write strobe |
| sp_wdata_o | output | 32 | New stack pointer |
| rf_we_o | output | 1 | Register write strobe |
| rf_waddr_o | output | 5 | Register index |
| rf_wdata_o | output | 32 | Register write data |
| pc_we_o | output | 1 | Program counter write strobe |
| pc_o | output | 32 | New program counter |

## Verification
The assertions watch the cycle-local rules on every clock. These rules are:
- reset quiescence;
- the held request and the missing write during a stall;
- the pairing of each register write with a one-word stack pointer step, and the read data it carries;
- the register index range;
- the single-cycle done pulse, and the program counter write appearing only together with done.

Only the bench scenarios can show the whole-sequence properties:
- the ascending pop order;
- the adjusted start address;
- the exact N+1 and N+3 latencies;
- empty masks;
- a start being ignored mid-sequence.

It gets these by comparing every output against a queue-based model on each cycle.

// File: rtl/frame_pop_pkg.sv
package frame_pop_pkg;

  typedef enum logic [2:0] {
    FP_IDLE,
    FP_ADJUST,
    FP_POP,
    FP_JWAIT,
    FP_JUMP
  } fp_state_e;

endpackage

// File: rtl/fp_lowest_pick.sv
module fp_lowest_pick #(
  parameter int MASK_W = 12,
  localparam int SLOT_W = $clog2(MASK_W)
) (
  input  logic [MASK_W-1:0] mask,
  output logic [SLOT_W-1:0] idx,
  output logic [MASK_W-1:0] rest
);

  logic [MASK_W-1:0] low_onehot;

  // isolate the lowest set bit, one slice per mask position
  genvar g;
  generate
    for (g = 0; g < MASK_W; g++) begin : g_iso
      if (g == 0) begin : g_first
        assign low_onehot[g] = mask[g];
      end else begin : g_rest
        assign low_onehot[g] = mask[g] & ~(|mask[g-1:0]);
      end
    end
  endgenerate

  always_comb begin
    idx = '0;
    for (int k = 0; k < MASK_W; k++) begin
      if (low_onehot[k]) idx = SLOT_W'(k);
    end
  end

  assign rest = mask & ~low_onehot;

endmodule

// File: rtl/fp_frame_math.sv
module fp_frame_math #(
  parameter int DATA_W     = 32,
  parameter int IMM_W      = 5,
  parameter int WORD_BYTES = 4,
  localparam int SHIFT     = $clog2(WORD_BYTES)
) (
  input  logic [DATA_W-1:0] base,
  input  logic [IMM_W-1:0]  imm,
  output logic [DATA_W-1:0] adjusted,
  output logic [DATA_W-1:0] stepped
);

  assign adjusted = base + (DATA_W'(imm) << SHIFT);
  assign stepped  = base + DATA_W'(WORD_BYTES);

endmodule

// File: rtl/frame_pop_seq.sv
module frame_pop_seq #(
  parameter int DATA_W     = 32,
  parameter int IMM_W      = 5,
  parameter int MASK_W     = 12,
  parameter int RIDX_W     = 5,
  parameter int REG_BASE   = 20,
  parameter int WORD_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [MASK_W-1:0] mask_i,
  input  logic              jump_i,
  input  logic [DATA_W-1:0] jump_target_i,
  input  logic [DATA_W-1:0] sp_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_addr_o,
  input  logic              rd_ready_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              sp_we_o,
  output logic [DATA_W-1:0] sp_wdata_o,
  output logic              rf_we_o,
  output logic [RIDX_W-1:0] rf_waddr_o,
  output logic [DATA_W-1:0] rf_wdata_o,
  output logic              pc_we_o,
  output logic [DATA_W-1:0] pc_o
);
  import frame_pop_pkg::*;

  localparam int SLOT_W = $clog2(MASK_W);

  fp_state_e         state_q;
  logic [MASK_W-1:0] mask_q;
  logic [IMM_W-1:0]  imm_q;
  logic              jump_q;
  logic [DATA_W-1:0] target_q;
  logic [DATA_W-1:0] sp_q;

  logic [SLOT_W-1:0] pick_idx;
  logic [MASK_W-1:0] pick_rest;
  logic [DATA_W-1:0] sp_adj;
  logic [DATA_W-1:0] sp_step;

  fp_lowest_pick #(.MASK_W(MASK_W)) u_pick (
    .mask (mask_q),
    .idx  (pick_idx),
    .rest (pick_rest)
  );

  fp_frame_math #(
    .DATA_W     (DATA_W),
    .IMM_W      (IMM_W),
    .WORD_BYTES (WORD_BYTES)
  ) u_math (
    .base     (sp_q),
    .imm      (imm_q),
    .adjusted (sp_adj),
    .stepped  (sp_step)
  );

  assign busy_o     = (state_q != FP_IDLE);
  assign rd_valid_o = (state_q == FP_POP);
  assign rd_addr_o  = sp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= FP_IDLE;
      mask_q     <= '0;
      imm_q      <= '0;
      jump_q     <= 1'b0;
      target_q   <= '0;
      sp_q       <= '0;
      done_o     <= 1'b0;
      sp_we_o    <= 1'b0;
      sp_wdata_o <= '0;
      rf_we_o    <= 1'b0;
      rf_waddr_o <= '0;
      rf_wdata_o <= '0;
      pc_we_o    <= 1'b0;
      pc_o       <= '0;
    end else begin
      done_o  <= 1'b0;
      sp_we_o <= 1'b0;
      rf_we_o <= 1'b0;
      pc_we_o <= 1'b0;
      unique case (state_q)
        FP_IDLE: begin
          if (start_i) begin
            mask_q   <= mask_i;
            imm_q    <= imm_i;
            jump_q   <= jump_i;
            target_q <= jump_target_i;
            sp_q     <= sp_i;
            state_q  <= FP_ADJUST;
          end
        end
        FP_ADJUST: begin
          sp_q       <= sp_adj;
          sp_we_o    <= 1'b1;
          sp_wdata_o <= sp_adj;
          if (|mask_q) begin
            state_q <= FP_POP;
          end else if (jump_q) begin
            state_q <= FP_JWAIT;
          end else begin
            state_q <= FP_IDLE;
            done_o  <= 1'b1;
          end
        end
        FP_POP: begin
          if (rd_ready_i) begin
            rf_we_o    <= 1'b1;
            rf_waddr_o <= RIDX_W'(REG_BASE) + RIDX_W'(pick_idx);
            rf_wdata_o <= rd_data_i;
            sp_q       <= sp_step;
            sp_we_o    <= 1'b1;
            sp_wdata_o <= sp_step;
            mask_q     <= pick_rest;
            if (pick_rest == '0) begin
              if (jump_q) begin
                state_q <= FP_JWAIT;
              end else begin
                state_q <= FP_IDLE;
                done_o  <= 1'b1;
              end
            end
          end
        end
        FP_JWAIT: begin
          state_q <= FP_JUMP;
        end
        FP_JUMP: begin
          pc_we_o <= 1'b1;
          pc_o    <= target_q;
          done_o  <= 1'b1;
          state_q <= FP_IDLE;
        end
        default: state_q <= FP_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/frame_pop_seq_chk.sv
module frame_pop_seq_chk #(
  parameter int DATA_W     = 32,
  parameter int RIDX_W     = 5,
  parameter int MASK_W     = 12,
  parameter int REG_BASE   = 20,
  parameter int WORD_BYTES = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              busy_o,
  input logic              done_o,
  input logic              rd_valid_o,
  input logic [DATA_W-1:0] rd_addr_o,
  input logic              rd_ready_i,
  input logic [DATA_W-1:0] rd_data_i,
  input logic              sp_we_o,
  input logic [DATA_W-1:0] sp_wdata_o,
  input logic              rf_we_o,
  input logic [RIDX_W-1:0] rf_waddr_o,
  input logic [DATA_W-1:0] rf_wdata_o,
  input logic              pc_we_o
);

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!busy_o && !done_o && !rd_valid_o && !sp_we_o && !rf_we_o && !pc_we_o)); // R1

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (rd_valid_o && !rd_ready_i) |=> (rd_valid_o && $stable(rd_addr_o))); // R5

  AST_STALL_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (rd_valid_o && !rd_ready_i) |=> !rf_we_o); // R5

  AST_POP_SP_STEP: assert property (@(posedge clk) disable iff (rst)
    rf_we_o |-> (sp_we_o && sp_wdata_o == $past(rd_addr_o) + DATA_W'(WORD_BYTES))); // R4

  AST_POP_DATA: assert property (@(posedge clk) disable iff (rst)
    rf_we_o |-> (rf_wdata_o == $past(rd_data_i))); // R3

  AST_REG_RANGE: assert property (@(posedge clk) disable iff (rst)
    rf_we_o |-> (rf_waddr_o >= RIDX_W'(REG_BASE) &&
                 rf_waddr_o <= RIDX_W'(REG_BASE + MASK_W - 1))); // R3

  AST_PC_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    pc_we_o |-> (done_o && !busy_o)); // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R6

endmodule

bind frame_pop_seq frame_pop_seq_chk #(
  .DATA_W     (DATA_W),
  .RIDX_W     (RIDX_W),
  .MASK_W     (MASK_W),
  .REG_BASE   (REG_BASE),
  .WORD_BYTES (WORD_BYTES)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .rd_valid_o (rd_valid_o),
  .rd_addr_o  (rd_addr_o),
  .rd_ready_i (rd_ready_i),
  .rd_data_i  (rd_data_i),
  .sp_we_o    (sp_we_o),
  .sp_wdata_o (sp_wdata_o),
  .rf_we_o    (rf_we_o),
  .rf_waddr_o (rf_waddr_o),
  .rf_wdata_o (rf_wdata_o),
  .pc_we_o    (pc_we_o)
);

// File: tb/frame_pop_seq_test.sv
`timescale 1ns/1ps
module frame_pop_seq_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [4:0]  imm_i = '0;
  logic [11:0] mask_i = '0;
  logic        jump_i = 1'b0;
  logic [31:0] jump_target_i = '0;
  logic [31:0] sp_i = '0;
  logic        busy_o, done_o, rd_valid_o, sp_we_o, rf_we_o, pc_we_o;
  logic [31:0] rd_addr_o, rd_data_i, sp_wdata_o, rf_wdata_o, pc_o;
  logic [4:0]  rf_waddr_o;
  logic        rd_ready_i = 1'b1;

  always #4 clk = ~clk;

  function automatic logic [31:0] memfn(logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h0BAD_F00D;
  endfunction

  assign rd_data_i = memfn(rd_addr_o);

  frame_pop_seq uut (
    .clk(clk), .rst(rst), .start_i(start_i), .imm_i(imm_i), .mask_i(mask_i),
    .jump_i(jump_i), .jump_target_i(jump_target_i), .sp_i(sp_i),
    .busy_o(busy_o), .done_o(done_o), .rd_valid_o(rd_valid_o),
    .rd_addr_o(rd_addr_o), .rd_ready_i(rd_ready_i), .rd_data_i(rd_data_i),
    .sp_we_o(sp_we_o), .sp_wdata_o(sp_wdata_o), .rf_we_o(rf_we_o),
    .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o), .pc_we_o(pc_we_o),
    .pc_o(pc_o)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int          m_phase = 0;
  int          m_q[$];
  logic [31:0] m_sp, m_tgt;
  logic [4:0]  m_imm;
  bit          m_jmp;
  bit          e_sp_we, e_rf_we, e_pc_we, e_done;
  logic [31:0] e_sp, e_rf_data, e_pc;
  int          e_rf_addr;

  always @(posedge clk) begin
    e_sp_we = 0; e_rf_we = 0; e_pc_we = 0; e_done = 0;
    if (rst) begin
      m_phase = 0;
      m_q.delete();
    end else begin
      case (m_phase)
        0: if (start_i) begin
          m_q.delete();
          for (int k = 0; k < 12; k++) if (mask_i[k]) m_q.push_back(k);
          m_sp = sp_i; m_imm = imm_i; m_jmp = jump_i; m_tgt = jump_target_i;
          m_phase = 1;
        end
        1: begin
          m_sp = m_sp + 32'(m_imm) * 4;
          e_sp_we = 1; e_sp = m_sp;
          if (m_q.size() > 0) m_phase = 2;
          else if (m_jmp) m_phase = 3;
          else begin m_phase = 0; e_done = 1; end
        end
        2: if (rd_ready_i) begin
          int k;
          k = m_q.pop_front();
          e_rf_we = 1; e_rf_addr = 20 + k; e_rf_data = memfn(m_sp);
          m_sp = m_sp + 4;
          e_sp_we = 1; e_sp = m_sp;
          if (m_q.size() == 0) begin
            if (m_jmp) m_phase = 3;
            else begin m_phase = 0; e_done = 1; end
          end
        end
        3: m_phase = 4;
        4: begin
          e_pc_we = 1; e_pc = m_tgt; e_done = 1; m_phase = 0;
        end
        default: m_phase = 0;
      endcase
    end
  end

  // ---------------- per-cycle comparison ----------------
  bit compare_on = 0;
  int busy_cnt = 0, rf_cnt = 0, pc_cnt = 0;
  int cur_n = 0;
  bit cur_jump = 0, cur_fast = 1;

  always @(negedge clk) begin
    if (compare_on && !finished) begin
      chk(busy_o == (m_phase != 0), "R6", "busy", busy_o, m_phase != 0);
      chk(done_o == e_done, "R6", "done", done_o, e_done);
      chk(rd_valid_o == (m_phase == 2), "R5", "rd_valid", rd_valid_o, m_phase == 2);
      if (m_phase == 2)
        chk(rd_addr_o == m_sp, "R3", "rd_addr", rd_addr_o, m_sp);
      chk(sp_we_o == e_sp_we, "R2", "sp_we", sp_we_o, e_sp_we);
      if (sp_we_o && e_sp_we)
        chk(sp_wdata_o == e_sp, "R4", "sp_wdata", sp_wdata_o, e_sp);
      chk(rf_we_o == e_rf_we, "R5", "rf_we", rf_we_o, e_rf_we);
      if (rf_we_o && e_rf_we) begin
        chk(rf_waddr_o == 5'(e_rf_addr), "R3", "rf_waddr", rf_waddr_o, e_rf_addr);
        chk(rf_wdata_o == e_rf_data, "R3", "rf_wdata", rf_wdata_o, e_rf_data);
      end
      chk(pc_we_o == e_pc_we, "R10", "pc_we", pc_we_o, e_pc_we);
      if (pc_we_o && e_pc_we)
        chk(pc_o == e_pc, "R7", "pc", pc_o, e_pc);

      if (busy_o) busy_cnt++;
      if (rf_we_o) rf_cnt++;
      if (pc_we_o) pc_cnt++;
      if (done_o) begin
        if (cur_fast)
          chk(busy_cnt == cur_n + (cur_jump ? 3 : 1), cur_jump ? "R7" : "R6",
              "latency", busy_cnt, cur_n + (cur_jump ? 3 : 1));
        chk(rf_cnt == cur_n, cur_n == 0 ? "R8" : "R9", "pop count", rf_cnt, cur_n);
        chk(pc_cnt == (cur_jump ? 1 : 0), cur_jump ? "R7" : "R10", "pc writes",
            pc_cnt, cur_jump ? 1 : 0);
        busy_cnt = 0; rf_cnt = 0; pc_cnt = 0;
      end
    end
  end

  // memory ready pattern
  logic [7:0] lfsr = 8'hA7;
  always @(negedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    rd_ready_i <= cur_fast ? 1'b1 : (lfsr[0] | lfsr[2]);
  end

  task automatic run_op(logic [4:0] imm, logic [11:0] mask, bit jmp, logic [31:0] tgt,
                        logic [31:0] sp, bit fast, bit poke);
    @(negedge clk);
    cur_n = $countones(mask); cur_jump = jmp; cur_fast = fast;
    start_i = 1; imm_i = imm; mask_i = mask; jump_i = jmp; jump_target_i = tgt; sp_i = sp;
    @(negedge clk);
    start_i = 0;
    if (poke) begin
      // R9: second start while busy with different values
      @(negedge clk);
      start_i = 1; imm_i = ~imm; mask_i = ~mask; jump_i = ~jmp; sp_i = ~sp;
      @(negedge clk);
      start_i = 0;
    end
    while (!done_o) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    compare_on = 1;
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: quiet after reset
    chk(!busy_o && !done_o && !rd_valid_o, "R1", "status after reset",
        {busy_o, done_o, rd_valid_o}, 0);
    chk(!sp_we_o && !rf_we_o && !pc_we_o, "R1", "strobes after reset",
        {sp_we_o, rf_we_o, pc_we_o}, 0);

    run_op(5'd3,  12'h025, 0, 32'h0,         32'h0000_1000, 1, 0); // R3 R6
    run_op(5'd31, 12'hFFF, 1, 32'h0004_2000, 32'h0000_8000, 1, 0); // R7 full mask
    run_op(5'd0,  12'h000, 0, 32'h0,         32'h0000_0400, 1, 0); // R8 plain
    run_op(5'd7,  12'h000, 1, 32'hCAFE_0010, 32'h0000_0800, 1, 0); // R8 with jump
    run_op(5'd2,  12'h801, 0, 32'h0,         32'h0000_2000, 0, 0); // R5 stalls
    run_op(5'd9,  12'h5A5, 1, 32'h0000_3344, 32'h0000_3000, 0, 0); // R5 R7 stalls
    run_op(5'd1,  12'h00F, 0, 32'h0,         32'h0000_5000, 1, 1); // R9
    run_op(5'd4,  12'h800, 0, 32'h0,         32'hFFFF_FFF0, 1, 0); // R3 top bit, wrap
    run_op(5'd0,  12'h3C0, 1, 32'h1234_5678, 32'h0000_6000, 1, 1); // R9 R7
    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule